// File: doc/BRIEF.md
# Externally Triggered Exposure Controller

This block is the sequencing state machine of an image-sensor timing generator. It runs a single exposure when an external trigger arrives. A two-bit mode select decides how the trigger is handled. One setting starts exposure on the next line sync, counts a programmed number of line syncs, and then fires the sensor gate. The other setting starts exposure on the next frame sync, counts the same way, and fires the gate on the first frame sync after the count has run out. The two remaining codes ignore the trigger.

When exposure starts, the block pulses the active-low substrate shutter for one clock. It can then request a one-clock discharge of residual vertical-register charge. An exposure-stop input can end exposure early. While the block is in triggered mode it raises a busy flag and forces the readout-mode output to the normal pattern. A standby input parks every output at a fixed safe level and sends the sequencer back to idle.

States: IDLE (waiting for a trigger), ARMED (trigger seen, waiting for the entry sync), START (substrate-shutter pulse, counter loaded, discharge decision taken), DISCHARGE (one-clock discharge request), EXPOSE (counting line syncs), WAIT_FRAME (count done in frame mode, waiting for a frame sync) and GATE (one-clock sensor-gate pulse). Transitions: IDLE→ARMED on a trigger rise with a valid mode; ARMED→START on the entry sync; START→DISCHARGE or START→EXPOSE; DISCHARGE→EXPOSE; EXPOSE→GATE (line mode, count zero) or EXPOSE→WAIT_FRAME (frame mode, count zero); WAIT_FRAME→GATE on a frame sync; any exposing state→GATE on an accepted stop edge; GATE→IDLE; any state→IDLE when standby is active.

Top module: `trig_expo_ctrl`

## Requirements
- R1: With mode_sel = 2'b01, a rising trigger edge makes the block enter triggered mode on the next rising line sync. sg_n then pulses low after exactly expo_len further rising line syncs. An expo_len of 0 ends exposure immediately.
- R2: With mode_sel = 2'b10, entry happens on the next rising frame sync. sg_n pulses low three clocks after the rising frame sync that follows the elapse of expo_len line syncs.
- R3: With mode_sel = 2'b00 or 2'b11, a trigger has no effect: busy stays low and sg_n stays high.
- R4: busy is high from the START state through the GATE state and is low on the clock after the sg_n pulse.
- R5: Each exposure produces exactly one sg_n low pulse, one clock wide.
- R6: sub_n pulses low for one clock at the start of each triggered exposure, while busy is high.
- R7: discharge_req pulses high for one clock right after START only if discharge_en and hs_shutter are both high when START is active. Otherwise there is no pulse.
- R8: A falling edge on expo_stop during exposure ends it with the sg_n pulse when shutter_en_n is low. When shutter_en_n is high the edge is ignored and exposure runs to its count.
- R9: A trigger edge that arrives while busy is high is ignored and starts no second exposure.
- R10: rdmode_out follows rdmode_in while idle and is forced to 0 (normal readout) while busy is high.
- R11: While standby_n is low, sg_n and sub_n are high, and busy, discharge_req and rdmode_out are low. The sequencer returns to IDLE and resumes no interrupted exposure.
- R12: While rst_n is low, sg_n and sub_n are high and busy and discharge_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Active-low standby |
| trig_in | input | 1 | External trigger (asynchronous, rising edge) |
| expo_stop | input | 1 | Exposure stop (asynchronous, falling edge) |
| line_sync | input | 1 | Line sync (asynchronous, rising edge) |
| frame_sync | input | 1 | Frame sync (asynchronous, rising edge) |
| mode_sel | input | 2 | Trigger mode: 01 line entry, 10 frame entry, others off |
| expo_len | input | CNT_W | Exposure length in line syncs |
| discharge_en | input | 1 | Request vertical-register discharge |
| hs_shutter | input | 1 | High-speed shutter selected |
| shutter_en_n | input | 1 | Active-low enable for stop-edge gating |
| rdmode_in | input | 1 | Requested readout mode (0 normal) |
| busy | output | 1 | Triggered mode active |
| sg_n | output | 1 | Sensor gate, active low |
| sub_n | output | 1 | Substrate shutter, active low |
| discharge_req | output | 1 | Vertical discharge request |
| rdmode_out | output | 1 | Effective readout mode |

## Verification
The vector table runs the trigger through every mode code with short, zero and long exposure lengths, and with each combination of discharge enable and high-speed shutter. Counting the line syncs between the busy rise and the gate separates exact line counting (line mode) from frame alignment (frame mode). A length longer than a frame shows that frame mode waits for the frame sync after the count has run out, not the first frame sync. Directed cases cover a retrigger while busy, stop edges with the enable low and high, standby during exposure, and reset during exposure.

// File: rtl/tec_pkg.sv
package tec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ARMED      = 3'd1,
        ST_START      = 3'd2,
        ST_DISCHARGE  = 3'd3,
        ST_EXPOSE     = 3'd4,
        ST_WAIT_FRAME = 3'd5,
        ST_GATE       = 3'd6
    } tec_state_e;

    localparam logic [1:0] MODE_LINE  = 2'b01;
    localparam logic [1:0] MODE_FRAME = 2'b10;
endpackage

// File: rtl/tec_sync_edge.sv
module tec_sync_edge #(
    parameter int          WIDTH     = 4,
    parameter logic [WIDTH-1:0] FALL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] idle_lvl,
    output logic [WIDTH-1:0] edge_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= idle_lvl[i];
                s2 <= idle_lvl[i];
                s3 <= idle_lvl[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        if (FALL_MASK[i]) begin : g_fall
            assign edge_o[i] = s3 & ~s2;
        end else begin : g_rise
            assign edge_o[i] = s2 & ~s3;
        end
    end
endmodule

// File: rtl/tec_expo_counter.sv
module tec_expo_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/trig_expo_ctrl.sv
module trig_expo_ctrl
    import tec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_n,
    input  logic             trig_in,
    input  logic             expo_stop,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] expo_len,
    input  logic             discharge_en,
    input  logic             hs_shutter,
    input  logic             shutter_en_n,
    input  logic             rdmode_in,
    output logic             busy,
    output logic             sg_n,
    output logic             sub_n,
    output logic             discharge_req,
    output logic             rdmode_out
);
    localparam int NSYNC = 4;
    localparam int I_TRIG  = 0;
    localparam int I_STOP  = 1;
    localparam int I_LINE  = 2;
    localparam int I_FRAME = 3;
    localparam logic [NSYNC-1:0] FALL_SEL = NSYNC'(1) << I_STOP;
    localparam logic [NSYNC-1:0] IDLE_LVL = NSYNC'(1) << I_STOP;

    logic [NSYNC-1:0] edges;
    logic trig_rise, stop_fall, line_rise, frame_rise;

    tec_sync_edge #(
        .WIDTH    (NSYNC),
        .FALL_MASK(FALL_SEL)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     ({frame_sync, line_sync, expo_stop, trig_in}),
        .idle_lvl(IDLE_LVL),
        .edge_o  (edges)
    );

    assign trig_rise  = edges[I_TRIG];
    assign stop_fall  = edges[I_STOP];
    assign line_rise  = edges[I_LINE];
    assign frame_rise = edges[I_FRAME];

    tec_state_e state_q, state_d;
    logic       frame_mode_q;
    logic       cnt_load, cnt_dec, cnt_zero;
    logic       entry_hit, stop_hit, mode_ok;

    assign mode_ok   = (mode_sel == MODE_LINE) || (mode_sel == MODE_FRAME);
    assign entry_hit = frame_mode_q ? frame_rise : line_rise;
    assign stop_hit  = stop_fall && !shutter_en_n;
    assign cnt_load  = (state_q == ST_ARMED) && entry_hit;
    assign cnt_dec   = (state_q == ST_EXPOSE) && line_rise;

    tec_expo_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(expo_len),
        .dec     (cnt_dec),
        .zero    (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            frame_mode_q <= 1'b0;
        end else if (!standby_n) begin
            state_q      <= ST_IDLE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && trig_rise && mode_ok) begin
                frame_mode_q <= (mode_sel == MODE_FRAME);
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_rise && mode_ok) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (entry_hit) state_d = ST_START;
            end
            ST_START: begin
                if (stop_hit)                        state_d = ST_GATE;
                else if (discharge_en && hs_shutter) state_d = ST_DISCHARGE;
                else                                 state_d = ST_EXPOSE;
            end
            ST_DISCHARGE: begin
                state_d = stop_hit ? ST_GATE : ST_EXPOSE;
            end
            ST_EXPOSE: begin
                if (stop_hit)          state_d = ST_GATE;
                else if (cnt_zero)     state_d = frame_mode_q ? ST_WAIT_FRAME : ST_GATE;
            end
            ST_WAIT_FRAME: begin
                if (stop_hit || frame_rise) state_d = ST_GATE;
            end
            ST_GATE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = 1'b0;
        sg_n          = 1'b1;
        sub_n         = 1'b1;
        discharge_req = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: ;
            ST_START: begin
                busy  = 1'b1;
                sub_n = 1'b0;
            end
            ST_DISCHARGE: begin
                busy          = 1'b1;
                discharge_req = 1'b1;
            end
            ST_EXPOSE, ST_WAIT_FRAME: busy = 1'b1;
            ST_GATE: begin
                busy = 1'b1;
                sg_n = 1'b0;
            end
            default: ;
        endcase
        if (!standby_n) begin
            busy          = 1'b0;
            sg_n          = 1'b1;
            sub_n         = 1'b1;
            discharge_req = 1'b0;
        end
        rdmode_out = rdmode_in && !busy && standby_n;
    end
endmodule

// File: rtl/trig_expo_ctrl_chk.sv
module trig_expo_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic standby_n,
    input logic busy,
    input logic sg_n,
    input logic sub_n,
    input logic discharge_req,
    input logic rdmode_out
);
    // R5
    gate_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_n |=> sg_n);

    // R4
    gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_n |-> busy);

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_n |=> !busy);

    // R6
    sub_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_n |=> sub_n);

    // R6
    sub_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_n |-> busy);

    // R7
    discharge_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (discharge_req && standby_n) |-> $past(!sub_n));

    // R10
    rdmode_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdmode_out);

    // R11
    standby_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |-> (sg_n && sub_n && !busy && !discharge_req && !rdmode_out));
endmodule

bind trig_expo_ctrl trig_expo_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_n    (standby_n),
    .busy         (busy),
    .sg_n         (sg_n),
    .sub_n        (sub_n),
    .discharge_req(discharge_req),
    .rdmode_out   (rdmode_out)
);

// File: tb/trig_expo_ctrl_tb.sv
module trig_expo_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_n = 1'b1;
    logic        trig_in = 1'b0;
    logic        expo_stop = 1'b1;
    logic        line_sync = 1'b0;
    logic        frame_sync = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [15:0] expo_len = '0;
    logic        discharge_en = 1'b0;
    logic        hs_shutter = 1'b0;
    logic        shutter_en_n = 1'b1;
    logic        rdmode_in = 1'b1;
    logic        busy, sg_n, sub_n, discharge_req, rdmode_out;

    always #10 clk = ~clk;

    trig_expo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .trig_in(trig_in),
        .expo_stop(expo_stop), .line_sync(line_sync), .frame_sync(frame_sync),
        .mode_sel(mode_sel), .expo_len(expo_len), .discharge_en(discharge_en),
        .hs_shutter(hs_shutter), .shutter_en_n(shutter_en_n), .rdmode_in(rdmode_in),
        .busy(busy), .sg_n(sg_n), .sub_n(sub_n), .discharge_req(discharge_req),
        .rdmode_out(rdmode_out)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // sync generators: line every 8 clocks, frame every 72, each 2 clocks high
    int gcyc = 0;
    always @(posedge clk) begin
        #2;
        gcyc <= gcyc + 1;
        line_sync  <= (gcyc % 8) < 2;
        frame_sync <= (gcyc % 72) < 2;
    end

    // monitor (negedge sampling)
    int gates, subs, dis, busy_rises, lines, gate_lines, frame_age, gate_age;
    int rd_viol, after_gate_err, width_err;
    logic p_busy = 0, p_line = 0, p_frame = 0, p_gate = 0;
    int wcyc = 0;
    always @(negedge clk) begin
        wcyc++;
        if (frame_sync && !p_frame) frame_age = 0; else frame_age++;
        if (busy && !p_busy) begin lines = 0; busy_rises++; end
        else if (busy && line_sync && !p_line) lines++;
        if (!sg_n) begin
            gates++;
            gate_lines = lines;
            gate_age = frame_age;
            if (p_gate) width_err++;
        end
        if (p_gate && busy) after_gate_err++;
        if (!sub_n) subs++;
        if (discharge_req) dis++;
        if (busy && rdmode_out) rd_viol++;
        p_busy = busy; p_line = line_sync; p_frame = frame_sync; p_gate = !sg_n;
        if (wcyc > 150000) begin
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wcyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic clr();
        gates = 0; subs = 0; dis = 0; busy_rises = 0; gate_lines = -1;
        rd_viol = 0; after_gate_err = 0; width_err = 0; gate_age = -1;
    endtask

    task automatic fire_trig();
        trig_in = 1'b1; tick(3); trig_in = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] len;
        logic        den;
        logic        hs;
        logic        exp_gate;
        logic        exp_dis;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 16'd3,  1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b01, 16'd0,  1'b1, 1'b1, 1'b1, 1'b1},
        '{2'b01, 16'd5,  1'b1, 1'b0, 1'b1, 1'b0},
        '{2'b10, 16'd2,  1'b0, 1'b1, 1'b1, 1'b0},
        '{2'b10, 16'd12, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'b00, 16'd3,  1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b11, 16'd3,  1'b1, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        clr();
        tick(3);
        // R12 reset levels
        chk(sg_n && sub_n && !busy && !discharge_req, "R12 reset levels",
            {sg_n, sub_n, busy, discharge_req}, 4'b1100);
        rst_n = 1'b1;
        tick(4);

        for (int v = 0; v < NV; v++) begin
            mode_sel = VECS[v].mode; expo_len = VECS[v].len;
            discharge_en = VECS[v].den; hs_shutter = VECS[v].hs;
            tick(2);
            clr();
            fire_trig();
            tick(260);
            // R1 R2 R3 gate count
            chk(gates == int'(VECS[v].exp_gate), "R1/R2/R3 gate count", gates, VECS[v].exp_gate);
            // R6
            chk(subs == int'(VECS[v].exp_gate), "R6 sub pulse count", subs, VECS[v].exp_gate);
            // R7
            chk(dis == int'(VECS[v].exp_dis), "R7 discharge count", dis, VECS[v].exp_dis);
            if (VECS[v].mode == 2'b01) begin
                // R1 exact line count
                chk(gate_lines == int'(VECS[v].len), "R1 lines to gate", gate_lines, VECS[v].len);
            end
            if (VECS[v].mode == 2'b10) begin
                // R2 frame aligned after count
                chk(gate_lines >= int'(VECS[v].len), "R2 lines before gate", gate_lines, VECS[v].len);
                chk(gate_age == 3, "R2 gate after frame sync", gate_age, 3);
            end
            // R4 R5
            chk(!busy && after_gate_err == 0, "R4 busy low after gate", after_gate_err, 0);
            chk(width_err == 0, "R5 gate width", width_err, 0);
            // R10
            chk(rd_viol == 0, "R10 readout forced while busy", rd_viol, 0);
            chk(rdmode_out == 1'b1, "R10 readout follows when idle", rdmode_out, 1);
        end

        // R9 retrigger while busy
        mode_sel = 2'b01; expo_len = 16'd10; discharge_en = 0; hs_shutter = 0;
        clr();
        fire_trig();
        tick(30);
        chk(busy == 1'b1, "R9 busy before retrigger", busy, 1);
        fire_trig();
        tick(200);
        chk(busy_rises == 1 && gates == 1, "R9 retrigger ignored", busy_rises, 1);

        // R8 stop edge with enable low
        expo_len = 16'd20; shutter_en_n = 1'b0;
        clr();
        fire_trig();
        tick(30);
        chk(busy == 1'b1, "R8 busy before stop", busy, 1);
        expo_stop = 1'b0; tick(3); expo_stop = 1'b1;
        tick(5);
        chk(!busy && gates == 1, "R8 stop ends exposure", gates, 1);
        chk(gate_lines < 20, "R8 stop cut count short", gate_lines, 20);

        // R8 stop edge ignored with enable high
        shutter_en_n = 1'b1;
        clr();
        fire_trig();
        tick(30);
        expo_stop = 1'b0; tick(3); expo_stop = 1'b1;
        tick(5);
        chk(busy == 1'b1 && gates == 0, "R8 stop ignored", gates, 0);
        tick(250);
        chk(gates == 1 && gate_lines == 20, "R8 full count after ignored stop", gate_lines, 20);

        // R11 standby during exposure
        expo_len = 16'd30;
        clr();
        fire_trig();
        tick(30);
        chk(busy == 1'b1, "R11 busy before standby", busy, 1);
        standby_n = 1'b0;
        tick(1);
        chk(sg_n && sub_n && !busy && !discharge_req && !rdmode_out, "R11 standby levels",
            {sg_n, sub_n, busy, discharge_req, rdmode_out}, 5'b11000);
        tick(5);
        standby_n = 1'b1;
        tick(300);
        chk(gates == 0 && !busy, "R11 no resume after standby", gates, 0);

        // R12 reset during exposure
        expo_len = 16'd30;
        clr();
        fire_trig();
        tick(30);
        rst_n = 1'b0;
        tick(1);
        chk(!busy && sg_n && sub_n && !discharge_req, "R12 reset mid exposure", busy, 0);
        rst_n = 1'b1;
        tick(300);
        chk(gates == 0 && !busy, "R12 idle after reset", gates, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule